// File: doc/BRIEF.md
# Housekeeping SPI Slave with Flash Bridge

This block is a mode-0 SPI slave with one chip select. A host reads a small bank of read-only housekeeping registers through it. One of these registers holds a fixed identity value. The host's SCK, CSB and SDI are oversampled by the system clock through a short synchronizer. All frame decoding happens in the system clock domain.

Every frame starts with an opcode byte. The opcode chooses one of three behaviours for the rest of the frame:
- a streaming register read, where the address counts up after each byte;
- a silent frame, for any opcode the block does not know;
- a bridge, where the host's clock and data go straight through to a downstream flash port and the flash's serial output comes back to the host.

During a bridge frame an attached processor is held in reset. The flash select and the processor reset are both released when the host ends the frame. The next frame is decoded as a normal opcode again.

Top module: `hk_spi_bridge`

## Requirements
- R1: After reset, host_sdo_o is 0, fl_csb_o is 1, fl_sck_o is 0 and cpu_rst_o is 0.
- R2: A frame starts when host_csb_i falls. Bits move MSB first and are sampled on host SCK rising edges. Opcode 0x40 is a streaming read: the byte after it is the register address, and each later byte returns register data on host_sdo_o. host_sdo_o is 0 during the opcode and address bytes. It changes only after an SCK falling edge or at frame end, and the first data bit is on the line before the first rising edge of the data byte.
- R3: Register address 0x03 reads as 0x11.
- R4: After each data byte the address goes up by one, and 0xFF wraps to 0x00. Addresses 0..7 other than 0x03 read as 0x50 plus the address. Addresses 8 and above read as 0x00.
- R5: Opcode 0xC4 starts a bridge. fl_csb_o stays 1 at the rising edge that completes the opcode and goes to 0 after the next SCK falling edge. From then on, host SCK and SDI are forwarded to fl_sck_o and fl_sdi_o, and fl_sdo_i is returned on host_sdo_o. fl_sck_o rises only while fl_csb_o is 0.
- R6: When host_csb_i returns high, fl_csb_o goes to 1 and cpu_rst_o goes to 0.
- R7: cpu_rst_o is 1 from the rising edge that completes a 0xC4 opcode until the frame ends, and 0 in all other frames. While fl_csb_o is 0, cpu_rst_o is 1.
- R8: Any other opcode makes the block ignore the rest of the frame: host_sdo_o stays 0, fl_csb_o stays 1 and cpu_rst_o stays 0.
- R9: A register read in the frame after a bridge frame returns correct data.
- R10: Raising host_csb_i in the middle of a byte drops the partial byte, and the next frame starts with a fresh opcode.
- R11: Outside a bridge, fl_csb_o is 1 and fl_sck_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the SPI pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_sck_i | input | 1 | Host serial clock |
| host_csb_i | input | 1 | Host chip select, active low |
| host_sdi_i | input | 1 | Host data into the slave |
| host_sdo_o | output | 1 | Slave data out to the host |
| fl_sdo_i | input | 1 | Serial data from the flash |
| fl_csb_o | output | 1 | Flash chip select, active low |
| fl_sck_o | output | 1 | Forwarded clock to the flash |
| fl_sdi_o | output | 1 | Forwarded data to the flash |
| cpu_rst_o | output | 1 | Processor reset hold, active high |

## Verification
The assertions assume that every host SCK phase and every CSB interval lasts well beyond the synchronizer depth plus one system clock, so each edge is seen as one separate event. They also assume SDI is stable across each sampled rising edge. The bench holds each SCK half-period for eight system clocks and changes SDI only while SCK is low. The flash model answers on the forwarded clock, so host_sdo_o settles several clocks before the host samples it.

// File: rtl/hkspi_pkg.sv
package hkspi_pkg;

  typedef enum logic [2:0] {
    ST_OPCODE,
    ST_ADDR,
    ST_DATA,
    ST_BRIDGE,
    ST_SKIP
  } frame_st_e;

  localparam logic [7:0] OP_STREAM_RD = 8'h40;
  localparam logic [7:0] OP_BRIDGE    = 8'hC4;

  // Fixed content of a plain housekeeping register.
  function automatic logic [7:0] bank_default(input logic [7:0] idx);
    return 8'h50 | {4'h0, idx[3:0]};
  endfunction

  // Bit of the outgoing byte to drive once cnt bits of this byte were clocked in.
  function automatic logic [2:0] next_bit_index(input logic [2:0] cnt);
    return 3'd7 - cnt;
  endfunction

endpackage

// File: rtl/hkspi_sync.sv
module hkspi_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_in,
  input  logic csb_in,
  input  logic sdi_in,
  output logic sck_q,
  output logic csb_q,
  output logic sdi_q,
  output logic sck_rise,
  output logic sck_fall
);
  logic [STAGES-1:0] sck_p, csb_p, sdi_p;
  logic              sck_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_p    <= '0;
      csb_p    <= '1;
      sdi_p    <= '0;
      sck_prev <= 1'b0;
    end else begin
      sck_p    <= {sck_p[STAGES-2:0], sck_in};
      csb_p    <= {csb_p[STAGES-2:0], csb_in};
      sdi_p    <= {sdi_p[STAGES-2:0], sdi_in};
      sck_prev <= sck_p[STAGES-1];
    end
  end

  assign sck_q    = sck_p[STAGES-1];
  assign csb_q    = csb_p[STAGES-1];
  assign sdi_q    = sdi_p[STAGES-1];
  assign sck_rise = sck_q & ~sck_prev;
  assign sck_fall = ~sck_q & sck_prev;
endmodule

// File: rtl/hkspi_regbank.sv
module hkspi_regbank #(
  parameter int         NUM_REGS = 8,
  parameter int         ID_ADDR  = 3,
  parameter logic [7:0] ID_VALUE = 8'h11
) (
  input  logic [7:0] rd_addr,
  output logic [7:0] rd_data
);
  localparam int         AW    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam logic [8:0] LIMIT = 9'(NUM_REGS);

  logic [7:0] rom [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    if (i == ID_ADDR) begin : g_id
      assign rom[i] = ID_VALUE;
    end else begin : g_plain
      assign rom[i] = hkspi_pkg::bank_default(8'(i));
    end
  end

  always_comb begin
    if ({1'b0, rd_addr} < LIMIT) rd_data = rom[rd_addr[AW-1:0]];
    else                         rd_data = 8'h00;
  end
endmodule

// File: rtl/hkspi_frame.sv
module hkspi_frame
  import hkspi_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       csb_q,
  input  logic       sdi_q,
  input  logic       sck_rise,
  input  logic       sck_fall,
  input  logic [7:0] rd_data,
  output logic [7:0] rd_addr,
  output logic       sdo_q,
  output logic       bridge_en,
  output logic       hold_cpu,
  output frame_st_e  state
);
  logic [2:0] bit_cnt;
  logic [6:0] shift;
  logic [7:0] tx_byte;
  logic [7:0] addr_ptr;
  logic [7:0] rx_full;
  logic       byte_end;

  assign rx_full  = {shift, sdi_q};
  assign byte_end = sck_rise & (bit_cnt == 3'd7);
  assign rd_addr  = (state == ST_ADDR) ? rx_full : addr_ptr + 8'd1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_OPCODE;
      bit_cnt   <= '0;
      shift     <= '0;
      tx_byte   <= '0;
      addr_ptr  <= '0;
      sdo_q     <= 1'b0;
      bridge_en <= 1'b0;
      hold_cpu  <= 1'b0;
    end else if (csb_q) begin
      state     <= ST_OPCODE;
      bit_cnt   <= '0;
      sdo_q     <= 1'b0;
      bridge_en <= 1'b0;
      hold_cpu  <= 1'b0;
    end else begin
      if (sck_rise) begin
        shift   <= rx_full[6:0];
        bit_cnt <= bit_cnt + 3'd1;
      end
      if (byte_end) begin
        case (state)
          ST_OPCODE: begin
            if (rx_full == OP_STREAM_RD) state <= ST_ADDR;
            else if (rx_full == OP_BRIDGE) begin
              state    <= ST_BRIDGE;
              hold_cpu <= 1'b1;
            end else state <= ST_SKIP;
          end
          ST_ADDR: begin
            addr_ptr <= rx_full;
            tx_byte  <= rd_data;
            state    <= ST_DATA;
          end
          ST_DATA: begin
            addr_ptr <= addr_ptr + 8'd1;
            tx_byte  <= rd_data;
          end
          default: ;
        endcase
      end
      if (sck_fall) begin
        if (state == ST_DATA)   sdo_q     <= tx_byte[next_bit_index(bit_cnt)];
        if (state == ST_BRIDGE) bridge_en <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/hk_spi_bridge.sv
module hk_spi_bridge #(
  parameter int         SYNC_STAGES = 2,
  parameter int         NUM_REGS    = 8,
  parameter int         ID_ADDR     = 3,
  parameter logic [7:0] ID_VALUE    = 8'h11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic host_sck_i,
  input  logic host_csb_i,
  input  logic host_sdi_i,
  output logic host_sdo_o,
  input  logic fl_sdo_i,
  output logic fl_csb_o,
  output logic fl_sck_o,
  output logic fl_sdi_o,
  output logic cpu_rst_o
);
  import hkspi_pkg::*;

  logic       sck_q, csb_q, sdi_q, sck_rise, sck_fall;
  logic [7:0] rd_addr, rd_data;
  logic       reg_sdo, bridge_en, hold_cpu;
  frame_st_e  state;
  logic       skip_active;

  hkspi_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .sck_in(host_sck_i), .csb_in(host_csb_i), .sdi_in(host_sdi_i),
    .sck_q(sck_q), .csb_q(csb_q), .sdi_q(sdi_q),
    .sck_rise(sck_rise), .sck_fall(sck_fall)
  );

  hkspi_frame u_frame (
    .clk(clk), .rst_n(rst_n),
    .csb_q(csb_q), .sdi_q(sdi_q),
    .sck_rise(sck_rise), .sck_fall(sck_fall),
    .rd_data(rd_data), .rd_addr(rd_addr),
    .sdo_q(reg_sdo), .bridge_en(bridge_en), .hold_cpu(hold_cpu),
    .state(state)
  );

  hkspi_regbank #(.NUM_REGS(NUM_REGS), .ID_ADDR(ID_ADDR), .ID_VALUE(ID_VALUE)) u_bank (
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  assign skip_active = (state == ST_SKIP);
  assign fl_csb_o    = ~bridge_en;
  assign fl_sck_o    = bridge_en & sck_q;
  assign fl_sdi_o    = bridge_en & sdi_q;
  assign host_sdo_o  = bridge_en ? fl_sdo_i : reg_sdo;
  assign cpu_rst_o   = hold_cpu;
endmodule

// File: rtl/hkspi_checker.sv
module hkspi_checker (
  input logic clk,
  input logic rst_n,
  input logic csb_q,
  input logic sck_fall,
  input logic reg_sdo,
  input logic skip_active,
  input logic host_sdo_o,
  input logic fl_csb_o,
  input logic fl_sck_o,
  input logic cpu_rst_o
);
  // R7: flash selected only while the processor is held
  a_r7_select_needs_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_csb_o |-> cpu_rst_o);

  // R6: frame end releases flash select and processor
  a_r6_release_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    csb_q |=> (!cpu_rst_o && fl_csb_o));

  // R11: no forwarded clock while flash is idle
  a_r11_idle_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
    fl_csb_o |-> !fl_sck_o);

  // R5: forwarded clock rises only inside a bridge
  a_r5_clock_in_bridge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fl_sck_o) |-> !fl_csb_o);

  // R8: unknown opcode keeps the host line low
  a_r8_skip_silent: assert property (@(posedge clk) disable iff (!rst_n)
    skip_active |-> !host_sdo_o);

  // R2: register data moves only after a falling edge or at frame end
  a_r2_sdo_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(reg_sdo) |-> ($past(sck_fall) || $past(csb_q)));
endmodule

bind hk_spi_bridge hkspi_checker u_chk (
  .clk(clk), .rst_n(rst_n), .csb_q(csb_q), .sck_fall(sck_fall),
  .reg_sdo(reg_sdo), .skip_active(skip_active), .host_sdo_o(host_sdo_o),
  .fl_csb_o(fl_csb_o), .fl_sck_o(fl_sck_o), .cpu_rst_o(cpu_rst_o)
);

// File: tb/sim_hk_spi_bridge.sv
module sim_hk_spi_bridge;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_sck = 1'b0, host_csb = 1'b1, host_sdi = 1'b0;
  logic host_sdo, fl_csb, fl_sck, fl_sdi, cpu_rst;
  logic fl_sdo = 1'b0;

  always #4 clk = ~clk;

  hk_spi_bridge u0 (
    .clk(clk), .rst_n(rst_n),
    .host_sck_i(host_sck), .host_csb_i(host_csb), .host_sdi_i(host_sdi),
    .host_sdo_o(host_sdo), .fl_sdo_i(fl_sdo), .fl_csb_o(fl_csb),
    .fl_sck_o(fl_sck), .fl_sdi_o(fl_sdi), .cpu_rst_o(cpu_rst)
  );

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  typedef struct {
    logic [7:0] exp;
    bit         chk;
    string      tag;
  } item_t;
  item_t sb[$];

  function automatic logic [7:0] expect_reg(input logic [7:0] a);
    if (a == 8'h03) return 8'h11;
    if (a < 8'd8)   return 8'h50 + a;
    return 8'h00;
  endfunction

  function automatic logic [7:0] flash_byte(input logic [23:0] a);
    logic [7:0] v;
    v = a[7:0] * 8'd7 + 8'h93;
    return v;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame_begin();
    host_csb = 1'b0;
    tick(HALF);
  endtask

  task automatic frame_end();
    tick(HALF);
    host_csb = 1'b1;
    tick(2 * HALF);
  endtask

  task automatic xfer(input logic [7:0] tx, input logic [7:0] exp, input bit chk, input string tag);
    item_t it;
    it.exp = exp; it.chk = chk; it.tag = tag;
    sb.push_back(it);
    for (int b = 7; b >= 0; b--) begin
      host_sdi = tx[b];
      tick(HALF);
      host_sck = 1'b1;
      tick(HALF);
      host_sck = 1'b0;
    end
  endtask

  // Bridge opcode with checks around its last rising edge and the next fall
  task automatic bridge_opcode();
    item_t it;
    logic [7:0] op;
    op = 8'hC4;
    it.exp = 8'h00; it.chk = 1'b0; it.tag = "R5";
    sb.push_back(it);
    for (int b = 7; b >= 0; b--) begin
      host_sdi = op[b];
      tick(HALF);
      host_sck = 1'b1;
      tick(HALF);
      if (b == 0) begin
        check("R5 flash idle at opcode end", {31'b0, fl_csb}, 32'd1);
        check("R7 hold from opcode end", {31'b0, cpu_rst}, 32'd1);
      end
      host_sck = 1'b0;
    end
    tick(HALF);
    check("R5 flash selected after fall", {31'b0, fl_csb}, 32'd0);
  endtask

  // Monitor: assemble host bytes and compare against the scoreboard
  logic [7:0] mon_sh = 8'h00;
  int mon_cnt = 0;
  always @(posedge host_sck) begin
    if (!host_csb) begin
      mon_sh = {mon_sh[6:0], host_sdo};
      mon_cnt++;
      if (mon_cnt == 8) begin
        mon_cnt = 0;
        if (sb.size() == 0) begin
          tests++; fails++;
          $display("FAIL R2: actual 0x%0h expected none (empty scoreboard)", mon_sh);
        end else begin
          item_t it;
          it = sb.pop_front();
          if (it.chk) check(it.tag, {24'b0, mon_sh}, {24'b0, it.exp});
        end
      end
    end
  end
  always @(posedge host_csb) mon_cnt = 0;

  // Flash model: opcode plus 3 address bytes, then a data stream
  int fl_bits = 0;
  logic [31:0] fl_rx = '0;
  always @(posedge fl_csb) begin
    fl_bits = 0;
    fl_sdo  = 1'b0;
  end
  always @(posedge fl_sck) begin
    if (!fl_csb) begin
      if (fl_bits < 32) fl_rx = {fl_rx[30:0], fl_sdi};
      fl_bits++;
    end
  end
  always @(negedge fl_sck) begin
    if (!fl_csb && fl_bits >= 32) begin
      logic [7:0] v;
      v = flash_byte(fl_rx[23:0] + 24'(fl_bits / 8 - 4));
      fl_sdo = v[7 - (fl_bits % 8)];
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    tick(5);
    rst_n = 1'b1;
    tick(4);
    check("R1 sdo", {31'b0, host_sdo}, 32'd0);
    check("R1 flash csb", {31'b0, fl_csb}, 32'd1);
    check("R1 flash sck", {31'b0, fl_sck}, 32'd0);
    check("R1 cpu reset", {31'b0, cpu_rst}, 32'd0);

    // ID register
    frame_begin();
    xfer(8'h40, 8'h00, 1'b1, "R2 opcode quiet");
    xfer(8'h03, 8'h00, 1'b1, "R2 address quiet");
    check("R7 no hold in register frame", {31'b0, cpu_rst}, 32'd0);
    xfer(8'hFF, 8'h11, 1'b1, "R3 id value");
    check("R11 flash idle in register frame", {30'b0, fl_csb, fl_sck}, 32'd2);
    frame_end();

    // Stream across the bank end
    frame_begin();
    xfer(8'h40, 8'h00, 1'b1, "R2");
    xfer(8'h02, 8'h00, 1'b1, "R2");
    for (int a = 2; a <= 8; a++) xfer(8'hA5, expect_reg(8'(a)), 1'b1, "R4 stream");
    frame_end();

    // Address wrap
    frame_begin();
    xfer(8'h40, 8'h00, 1'b1, "R2");
    xfer(8'hFE, 8'h00, 1'b1, "R2");
    xfer(8'h00, expect_reg(8'hFE), 1'b1, "R4 wrap");
    xfer(8'h00, expect_reg(8'hFF), 1'b1, "R4 wrap");
    xfer(8'h00, expect_reg(8'h00), 1'b1, "R4 wrap");
    xfer(8'h00, expect_reg(8'h01), 1'b1, "R4 wrap");
    frame_end();

    // Unknown opcode
    frame_begin();
    xfer(8'h5A, 8'h00, 1'b1, "R8");
    xfer(8'h03, 8'h00, 1'b1, "R8");
    xfer(8'hFF, 8'h00, 1'b1, "R8");
    check("R8 flash stays idle", {31'b0, fl_csb}, 32'd1);
    check("R8 no hold", {31'b0, cpu_rst}, 32'd0);
    frame_end();

    // Bridge to flash
    frame_begin();
    bridge_opcode();
    xfer(8'h03, 8'h00, 1'b0, "R5");
    xfer(8'h00, 8'h00, 1'b0, "R5");
    xfer(8'h00, 8'h00, 1'b0, "R5");
    xfer(8'h10, 8'h00, 1'b0, "R5");
    check("R7 hold during bridge", {31'b0, cpu_rst}, 32'd1);
    for (int n = 0; n < 3; n++) xfer(8'h00, flash_byte(24'h10 + 24'(n)), 1'b1, "R5 flash data");
    check("R5 flash received opcode and address", fl_rx, 32'h03000010);
    tick(HALF);
    check("R6 flash selected before frame end", {31'b0, fl_csb}, 32'd0);
    host_csb = 1'b1;
    tick(2 * HALF);
    check("R6 flash released", {31'b0, fl_csb}, 32'd1);
    check("R6 processor released", {31'b0, cpu_rst}, 32'd0);

    // Register access after a bridge
    frame_begin();
    xfer(8'h40, 8'h00, 1'b1, "R9");
    xfer(8'h03, 8'h00, 1'b1, "R9");
    xfer(8'h00, 8'h11, 1'b1, "R9 id after bridge");
    xfer(8'h00, 8'h54, 1'b1, "R9 next after bridge");
    frame_end();

    // Aborted partial opcode
    frame_begin();
    for (int b = 7; b >= 4; b--) begin
      host_sdi = b[0] ^ 1'b1;
      tick(HALF);
      host_sck = 1'b1;
      tick(HALF);
      host_sck = 1'b0;
    end
    frame_end();
    check("R10 no hold after abort", {31'b0, cpu_rst}, 32'd0);
    frame_begin();
    xfer(8'h40, 8'h00, 1'b1, "R10");
    xfer(8'h03, 8'h00, 1'b1, "R10");
    xfer(8'h00, 8'h11, 1'b1, "R10 fresh opcode");
    frame_end();

    check("R2 scoreboard drained", sb.size(), 32'd0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule